// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Sequencer

This block sits between a simple request port and an asynchronous DRAM whose address pins are shared between row and column. A requester presents a full address, a read or write flag, write data and an output-enable mode, and holds the request until a one-cycle ready pulse comes back. For reads, the data arrives with that pulse. The sequencer splits the address and puts the row on the pins when the row strobe falls. It then puts the column on the pins when the column strobe falls. Four minimum intervals are each held by their own down-counter: row-to-data, column-to-data, row-to-row and column-to-column.

Each interval is given in nanoseconds together with the clock period. It is turned into a whole number of cycles by rounding up, with a minimum of one. A free-running refresh timer raises a request once per period. When the current access ends, that request wins over a waiting user request. It is served with a row-only access to the next row in a wrapping sequence. The data pins are split into an output, an output enable and an input, so that the tristate sits in the pad ring.

Top module: `dram_seq_ctrl`

## Requirements
- R1: The upper ROW_W bits of `req_addr` form the row and the lower COL_W bits form the column. `mem_addr` carries the row when `ras_n` falls and the column when `cas_n` falls. `cas_n` is low only while `ras_n` is low.
- R2: Read data is captured no earlier than RAC cycles after `ras_n` fell and no earlier than CAC cycles after `cas_n` fell. It equals the last value written to that address. Each cycle count is the ceiling of the nanosecond value divided by CLK_NS.
- R3: Two successive falls of `ras_n`, whether from user accesses or refresh, are at least RC cycles apart.
- R4: Two successive falls of `cas_n` are at least PC cycles apart.
- R5: With `req_late_oe`=0, `oe_n` is already low in the cycle before `cas_n` falls. With `req_late_oe`=1, `oe_n` is still high when `cas_n` falls and goes low afterwards. Both modes return the same data.
- R6: A write asserts `we_n` low and `dq_oe` high, with `dq_out` = `req_wdata`, in the cycle before `cas_n` falls. `oe_n` stays high for the whole write.
- R7: A refresh is a fall of `ras_n` with no fall of `cas_n`. It holds `ras_n` low for at least RAC cycles. Refreshed rows follow 0, 1, 2 and so on, wrapping to 0 after the last row.
- R8: A refresh starts no later than REFRESH_CYC + 2*RC + 4 cycles after the previous refresh. A due refresh goes ahead of a waiting user request.
- R9: `dq_oe` is high only during write cycles and is never high while `oe_n` is low.
- R10: `req_ready` is high for exactly one cycle per request. No new request is accepted in that cycle.
- R11: During and straight after reset, all four strobes are high, `req_ready` is low and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_late_oe | input | 1 | 1 = output enable after column strobe (late read) |
| req_addr | input | ROW_W+COL_W | Row (upper bits) and column (lower bits) |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `req_ready` |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | DATA_W | Data to DRAM |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | DATA_W | Data from DRAM |

## Verification
The bench DRAM model drives inverted data until both the row-to-data and column-to-data windows have expired. A sequencer that samples even one cycle early therefore returns a visibly wrong word. Back-to-back random traffic keeps the row-cycle gate busy. A missing or short row-cycle count shows up as a spacing fault at the model. Letting a user access jump ahead of a due refresh stretches the gap between refreshes beyond its bound. A long idle stretch runs the refresh row counter past its last row, so a counter that fails to wrap breaks the expected row sequence. Directed reads in both output-enable modes catch a late read that enables too early and an early read that enables too late.

// File: rtl/dseq_pkg.sv
// Shared types and helpers for the DRAM strobe sequencer.
// Assumes all timing values are non-negative and the period is non-zero.
package dseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // strobes high, waiting for work
        ST_ROW,    // row on pins, waiting for row-cycle window
        ST_RAS,    // row strobe low
        ST_COL,    // column on pins, write data / early OE set up
        ST_CAS,    // column strobe just fell
        ST_DATA    // waiting for data windows to expire
    } dseq_state_e;

    localparam int TIM_RAC = 0;
    localparam int TIM_CAC = 1;
    localparam int TIM_PC  = 2;
    localparam int TIM_RC  = 3;
    localparam int TIM_N   = 4;

    // Rounds a nanosecond interval up to whole cycles, never below one.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/dseq_interval.sv
// Minimum-interval down-counter. Loading `load` on `start` makes `done`
// rise `load` cycles later, so an action gated by `done` happens no sooner
// than load+1 edges after the starting edge. Idle (done) out of reset.
module dseq_interval #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Reload on start, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= load;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dseq_refresh.sv
// Refresh scheduler: raises `pend` once every PERIOD cycles and keeps it
// until `ack`. `row` is the next row to refresh and advances on `ack`,
// wrapping after the last row. Assumes PERIOD >= 2.
module dseq_refresh #(
    parameter int unsigned ROW_W  = 4,
    parameter int unsigned PERIOD = 1560
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int unsigned CW = $clog2(PERIOD + 1);

    logic [CW-1:0] tick_q;
    logic          expire;

    assign expire = (tick_q == CW'(PERIOD - 1));

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      tick_q <= '0;
        else if (expire) tick_q <= '0;
        else             tick_q <= tick_q + 1'b1;
    end

    // Pending flag: set on expiry, cleared when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (expire) pend <= 1'b1;
        else if (ack)    pend <= 1'b0;
    end

    // Row pointer advances once per refresh, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (ack) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_seq_ctrl.sv
// DRAM strobe sequencer top. Accepts one held request at a time, runs the
// row/column strobe sequence under four minimum-interval counters, and
// interleaves row-only refresh cycles. Strobes are decoded from the state
// register. Assumes the requester drops req_valid in its ready cycle.
module dram_seq_ctrl
    import dseq_pkg::*;
#(
    parameter int unsigned ROW_W       = 4,
    parameter int unsigned COL_W       = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CLK_NS      = 5,
    parameter int unsigned TRAC_NS     = 60,
    parameter int unsigned TRC_NS      = 110,
    parameter int unsigned TCAC_NS     = 15,
    parameter int unsigned TPC_NS      = 35,
    parameter int unsigned REFRESH_CYC = 1560,
    localparam int unsigned AW         = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_late_oe,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_ready,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [AW-1:0]          mem_addr,
    output logic                   ras_n,
    output logic                   cas_n,
    output logic                   we_n,
    output logic                   oe_n,
    output logic [DATA_W-1:0]      dq_out,
    output logic                   dq_oe,
    input  logic [DATA_W-1:0]      dq_in
);
    localparam int unsigned RAC_CYC = ns2cyc(TRAC_NS, CLK_NS);
    localparam int unsigned CAC_CYC = ns2cyc(TCAC_NS, CLK_NS);
    localparam int unsigned PC_CYC  = ns2cyc(TPC_NS,  CLK_NS);
    localparam int unsigned RC_CYC  = ns2cyc(TRC_NS,  CLK_NS);
    localparam int unsigned MAX_AB  = (RAC_CYC > CAC_CYC) ? RAC_CYC : CAC_CYC;
    localparam int unsigned MAX_CD  = (PC_CYC  > RC_CYC)  ? PC_CYC  : RC_CYC;
    localparam int unsigned MAXC    = (MAX_AB  > MAX_CD)  ? MAX_AB  : MAX_CD;
    localparam int unsigned TW      = $clog2(MAXC + 1);
    localparam int unsigned LOADS [TIM_N] = '{RAC_CYC - 1, CAC_CYC - 1, PC_CYC - 1, RC_CYC - 1};

    dseq_state_e        state_q, state_d;
    logic [TIM_N-1:0]   tim_start, tim_done;
    logic               accept, ref_ack, finish;
    logic               ref_pend;
    logic [ROW_W-1:0]   ref_row;
    logic               is_wr_q, is_ref_q, late_q, ready_q;
    logic [ROW_W-1:0]   row_q;
    logic [COL_W-1:0]   col_q;
    logic [DATA_W-1:0]  wdata_q, rdata_q;
    logic               col_phase, is_read;

    // One interval counter per timing rule.
    for (genvar g = 0; g < TIM_N; g++) begin : g_tim
        dseq_interval #(.W(TW)) u_tim (
            .clk   (clk),
            .rst_n (rst_n),
            .start (tim_start[g]),
            .load  (TW'(LOADS[g])),
            .done  (tim_done[g])
        );
    end

    dseq_refresh #(.ROW_W(ROW_W), .PERIOD(REFRESH_CYC)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .pend  (ref_pend),
        .row   (ref_row)
    );

    // Next-state logic with timer gating and refresh priority.
    always_comb begin
        state_d   = state_q;
        tim_start = '0;
        accept    = 1'b0;
        ref_ack   = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_ack = 1'b1;
                    state_d = ST_ROW;
                end else if (req_valid && !ready_q) begin
                    accept  = 1'b1;
                    state_d = ST_ROW;
                end
            end
            ST_ROW: begin
                if (tim_done[TIM_RC]) begin
                    tim_start[TIM_RC]  = 1'b1;
                    tim_start[TIM_RAC] = 1'b1;
                    state_d = ST_RAS;
                end
            end
            ST_RAS: begin
                if (!is_ref_q)             state_d = ST_COL;
                else if (tim_done[TIM_RAC]) state_d = ST_IDLE;
            end
            ST_COL: begin
                if (tim_done[TIM_PC]) begin
                    tim_start[TIM_PC]  = 1'b1;
                    tim_start[TIM_CAC] = 1'b1;
                    state_d = ST_CAS;
                end
            end
            ST_CAS: state_d = ST_DATA;
            ST_DATA: begin
                if (tim_done[TIM_RAC] && tim_done[TIM_CAC]) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            is_wr_q  <= 1'b0;
            is_ref_q <= 1'b0;
            late_q   <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
            wdata_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                is_wr_q  <= req_write;
                is_ref_q <= 1'b0;
                late_q   <= req_late_oe;
                row_q    <= req_addr[ROW_W+COL_W-1 -: ROW_W];
                col_q    <= req_addr[COL_W-1:0];
                wdata_q  <= req_wdata;
            end else if (ref_ack) begin
                is_wr_q  <= 1'b0;
                is_ref_q <= 1'b1;
                row_q    <= ref_row;
            end
        end
    end

    // Completion pulse and read-data capture at the sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= finish;
            if (finish && !is_wr_q) rdata_q <= dq_in;
        end
    end

    // Strobe and bus decode from the state register.
    assign col_phase = (state_q == ST_COL) || (state_q == ST_CAS) || (state_q == ST_DATA);
    assign is_read   = !is_wr_q && !is_ref_q;
    assign ras_n     = !(col_phase || (state_q == ST_RAS));
    assign cas_n     = !((state_q == ST_CAS) || (state_q == ST_DATA));
    assign mem_addr  = col_phase ? AW'(col_q) : AW'(row_q);
    assign we_n      = !(is_wr_q && col_phase);
    assign dq_oe     = is_wr_q && col_phase;
    assign dq_out    = wdata_q;
    assign oe_n      = !(is_read && (late_q ? (state_q == ST_DATA) : col_phase));
    assign req_ready = ready_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/dseq_checker.sv
// Protocol checker for the DRAM strobe sequencer, bound into the top.
// Gap counters saturate and start saturated, so a first event never fails.
module dseq_checker #(
    parameter int unsigned RAC_CYC = 12,
    parameter int unsigned PC_CYC  = 7,
    parameter int unsigned RC_CYC  = 22
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic req_ready
);
    logic [15:0] ras_gap, cas_gap;
    logic        ras_prev, cas_prev;

    // Cycles since the last observed strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev <= 1'b1;
            cas_prev <= 1'b1;
            ras_gap  <= 16'hFFFF;
            cas_gap  <= 16'hFFFF;
        end else begin
            ras_prev <= ras_n;
            cas_prev <= cas_n;
            if (ras_prev && !ras_n)     ras_gap <= 16'd1;
            else if (ras_gap != 16'hFFFF) ras_gap <= ras_gap + 16'd1;
            if (cas_prev && !cas_n)     cas_gap <= 16'd1;
            else if (cas_gap != 16'hFFFF) cas_gap <= cas_gap + 16'd1;
        end
    end

    a_r1_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    a_r3_row_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_prev && !ras_n) |-> ras_gap >= RC_CYC);
    a_r4_col_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_prev && !cas_n) |-> cas_gap >= PC_CYC);
    a_r2_data_after_rac: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ras_gap >= RAC_CYC);
    a_r10_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
    a_r9_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    a_r6_data_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_prev && !cas_n && !we_n) |-> $past(dq_oe));
endmodule

bind dram_seq_ctrl dseq_checker #(
    .RAC_CYC (RAC_CYC),
    .PC_CYC  (PC_CYC),
    .RC_CYC  (RC_CYC)
) u_dseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe),
    .req_ready (req_ready)
);

// File: tb/test_dram_seq_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural DRAM model with interval checks, directed corners and
// seeded random traffic compared against a reference memory.
module test_dram_seq_ctrl;
    localparam int ROW_W = 4, COL_W = 4, DATA_W = 8, AW = 4;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int REF_P = 150;
    localparam int RAC = (60 + 4) / 5, CAC = (15 + 4) / 5;
    localparam int PC = (35 + 4) / 5, RC = (110 + 4) / 5;
    localparam int REF_BOUND = REF_P + 2 * RC + 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_late_oe = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready;
    logic [DATA_W-1:0] rsp_rdata, dq_out, dq_in;
    logic [AW-1:0] mem_addr;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;

    int total = 0, bad = 0;
    bit finished = 1'b0, model_on = 1'b0, exp_late = 1'b0;

    always #2.5 clk = ~clk;

    dram_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CLK_NS(5),
        .TRAC_NS(60), .TRC_NS(110), .TCAC_NS(15), .TPC_NS(35),
        .REFRESH_CYC(REF_P)) i_dram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_late_oe(req_late_oe), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [DATA_W-1:0] mem [1 << ADDR_W];
    logic [DATA_W-1:0] ref_mem [1 << ADDR_W];
    logic [ROW_W-1:0] cur_row = '0, exp_ref_row = '0;
    logic [COL_W-1:0] cur_col = '0;
    bit prev_ras = 1, prev_cas = 1, prev_oe = 1, prev_we = 1, saw_cas = 0, rd_valid = 0;
    int cyc = 0, ras_fall = -1000, cas_fall = -1000, last_ref = 0, ref_count = 0;

    assign dq_in = (!oe_n && !cas_n) ? (rd_valid ? mem[{cur_row, cur_col}] : ~mem[{cur_row, cur_col}]) : '0;

    initial for (int i = 0; i < (1 << ADDR_W); i++) begin mem[i] = '0; ref_mem[i] = '0; end

    // Strobe monitor: tracks edges at each falling clock edge and checks rules.
    always @(negedge clk) if (model_on) begin
        cyc++;
        check(!(dq_oe && !oe_n) && (dq_oe == !we_n), "R9 bus drive", {dq_oe, oe_n, we_n}, 0);
        if (!cas_n && ras_n) check(0, "R1 cas outside ras", 1, 0);
        if (prev_ras && !ras_n) begin
            check(cyc - ras_fall >= RC, "R3 row cycle", cyc - ras_fall, RC);
            cur_row = mem_addr[ROW_W-1:0];
            ras_fall = cyc;
            saw_cas = 0;
        end
        if (prev_cas && !cas_n) begin
            check(cyc - cas_fall >= PC, "R4 column cycle", cyc - cas_fall, PC);
            cur_col = mem_addr[COL_W-1:0];
            cas_fall = cyc;
            saw_cas = 1;
            if (!we_n) begin
                check(!prev_we && dq_oe && oe_n, "R6 write setup", {prev_we, dq_oe, oe_n}, 3'b011);
                mem[{cur_row, cur_col}] = dq_out;
            end else if (!exp_late) begin
                check(!prev_oe, "R5 early oe before cas", prev_oe, 0);
            end else begin
                check(oe_n, "R5 late oe after cas", oe_n, 1);
            end
        end
        if (!prev_ras && ras_n && !saw_cas) begin
            check(cur_row == exp_ref_row, "R7 refresh row", cur_row, exp_ref_row);
            check(cyc - ras_fall >= RAC, "R7 refresh ras width", cyc - ras_fall, RAC);
            check(ras_fall - last_ref <= REF_BOUND, "R8 refresh gap", ras_fall - last_ref, REF_BOUND);
            last_ref = ras_fall;
            exp_ref_row = exp_ref_row + 1'b1;
            ref_count++;
        end
        rd_valid = !ras_n && !cas_n && (cyc - ras_fall >= RAC - 1) && (cyc - cas_fall >= CAC - 1);
        prev_ras = ras_n; prev_cas = cas_n; prev_oe = oe_n; prev_we = we_n;
    end

    // ---------------- request driver ----------------
    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit late);
        int n;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_late_oe = late; exp_late = late;
        n = 0;
        do begin @(negedge clk); n++; end while (!req_ready && n < 300);
        check(req_ready, "R10 ready seen", req_ready, 1);
        if (!wr) check(rsp_rdata == ref_mem[a], late ? "R2 R5 late read data" : "R2 R5 early read data", rsp_rdata, ref_mem[a]);
        else ref_mem[a] = d;
        req_valid = 0;
        @(negedge clk);
        check(!req_ready, "R10 ready one cycle", req_ready, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        check(ras_n && cas_n && we_n && oe_n && !req_ready && !dq_oe, "R11 reset outputs",
              {ras_n, cas_n, we_n, oe_n, req_ready, dq_oe}, 6'b111100);
        rst_n = 1;
        model_on = 1;
        @(negedge clk);
        check(ras_n && cas_n && !req_ready && !dq_oe, "R11 after reset", {ras_n, cas_n, req_ready, dq_oe}, 4'b1100);
        // Directed corners: extreme addresses, both read modes, R1 address split.
        access(1, 8'h00, 8'h5A, 0);
        access(1, 8'hFF, 8'hC3, 0);
        access(1, 8'hF0, 8'h0F, 0);
        access(0, 8'hFF, 0, 0);
        access(0, 8'hFF, 0, 1);
        access(0, 8'h00, 0, 1);
        access(0, 8'hF0, 0, 0);
        check(mem[8'hF0] == 8'h0F && mem[8'h0F] == 8'h00, "R1 row/column split", mem[8'hF0], 8'h0F);
        // Random back-to-back traffic.
        for (int k = 0; k < 260; k++)
            access(1'($urandom % 2), 8'($urandom), 8'($urandom), 1'($urandom % 2));
        // Idle stretch so refresh keeps running and wraps.
        repeat (20 * REF_P) @(negedge clk);
        check(ref_count > (1 << ROW_W), "R7 refresh wrap count", ref_count, (1 << ROW_W) + 1);
        for (int a = 0; a < 16; a++) access(0, 8'(a * 17), 0, 1'(a % 2));
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule